// File: doc/BRIEF.md
# Dual-Rate Center-Aligned PWM Timebase

This block generates center-aligned pulse-width modulation for two power stages from one clock. The first stage is a three-phase motor inverter and the second is a two-phase interleaved boost power-factor stage. A slow triangle counter drives the inverter. A fast triangle counter drives the boost stage. The fast period is one tenth of the slow period, and the slow counter forces the fast one back to zero at every slow wrap, so the two timebases can never drift apart.

Each inverter phase compares the slow counter with its own duty value. The result becomes a complementary high/low pair with a programmable dead band. The two boost phases share the fast counter. Phase A is centered on the counter valley, and phase B uses the reflected compare so that it is centered on the peak, 180 degrees away.

Duty values go into shadow registers and reach the comparators only when the counter wraps to zero. Start-of-conversion strobes fire at each counter peak, the point farthest from any switching edge. A single-cycle control interrupt request follows every second fast peak after a fixed conversion delay. When the enable input is low, both counters are held at zero and every drive output is low.

Top module: `pwm_dual_timebase`

## Requirements
- R1: While reset is asserted, every output (`pfc_pwm`, `inv_hi`, `inv_lo`, `pfc_soc`, `inv_soc`, `isr_req`) is 0.
- R2: With `en` low, both counters are held at zero and all outputs are 0 from the first clock edge that samples `en` low. After `en` rises, `pfc_soc` first appears FAST_HALF edges later and `inv_soc` first appears SLOW_HALF = RATIO*FAST_HALF edges later.
- R3: The fast counter period is 2*FAST_HALF clocks and the slow counter period is RATIO times longer (default RATIO=10). `pfc_soc` pulses once per fast period and `inv_soc` once per slow period. Because of the resync at the slow wrap, the first `pfc_soc` after an `inv_soc` comes exactly FAST_HALF clocks later.
- R4: Boost phase A (`pfc_pwm[0]`) is high while the fast count is below the active compare C. Boost phase B (`pfc_pwm[1]`) is high while count + C exceeds FAST_HALF. Each phase is therefore high 2C-1 clocks per fast period for 1 <= C <= FAST_HALF, never for C=0, and always for C > FAST_HALF.
- R5: The two boost phases are 180 degrees apart. For a small compare, in the cycle where `pfc_soc` is high, phase B is high and phase A is low.
- R6: For inverter phase i, the raw signal is high while the slow count is below its compare. `inv_hi[i]` is high for (raw high length - dead_time) clocks of each raw-high interval, and `inv_lo[i]` for (raw low length - dead_time) clocks of each raw-low interval. With dead_time = 0 the pair simply follows raw and its complement.
- R7: `inv_hi[i]` and `inv_lo[i]` are never high in the same cycle.
- R8: A raw interval no longer than `dead_time` produces no pulse on the corresponding output. With a compare equal to SLOW_HALF, `inv_lo` stays low.
- R9: A compare written mid-period has no effect until the owning counter wraps to zero. The new value applies from the next period on.
- R10: `isr_req` is a one-cycle pulse that follows every second `pfc_soc` by ISR_DLY clocks, counting from the first fast peak after a slow wrap. This gives RATIO/2 requests per slow period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds counters at zero and drives outputs low |
| dead_time | input | DT_W | Dead band in clocks for every complementary pair |
| pfc_cmp_wr | input | 1 | Write strobe for the boost compare shadow |
| pfc_cmp_in | input | CNT_W | Boost compare value |
| inv_cmp_wr | input | PHASES | Per-phase write strobes for the inverter compare shadows |
| inv_cmp_in | input | PHASES*CNT_W | Inverter compare values, phase i at bits [i*CNT_W +: CNT_W] |
| pfc_pwm | output | 2 | Boost phase drives; bit 0 valley-centered, bit 1 peak-centered |
| inv_hi | output | PHASES | Inverter high-side drives |
| inv_lo | output | PHASES | Inverter low-side drives |
| pfc_soc | output | 1 | Conversion start at each fast peak |
| inv_soc | output | 1 | Conversion start at each slow peak |
| isr_req | output | 1 | Control interrupt request pulse |

## Verification
The bench uses several boost compare values: a mid value, zero, exactly the half-period, and above the half-period. Between them they separate the 2C-1 pulse law from off-by-one compares and from the saturation ends of both phases. On the inverter side the three phases run a mid duty, zero duty and a duty equal to the half-period all at once. This shows the dead-band subtraction, the always-on low side, and the removal of a pulse shorter than the dead band. It then repeats with no dead band to tell subtraction from a fixed offset. A write made just after the inverter peak, probed twenty clocks later, tells shadowed loading from immediate loading. Start-up delays after enable, and the gap from an inverter strobe to the next boost strobe, show the counters at zero and the resync phase.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Per-timebase event flags shared by the counters and their users
  typedef struct packed {
    logic at_peak;  // counter sits at its half-period value while running
    logic wrap;     // counter will be zero after the next edge
  } tb_flags_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HALF  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             resync,
  output logic [CNT_W-1:0] cnt,
  output tb_flags_t        flags
);
  localparam logic [CNT_W-1:0] TOP    = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] TOP_M1 = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  // next-state: triangle 0..HALF..1, forced to zero by disable or resync
  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!en || resync) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (up_q) begin
      cnt_d = cnt_q + ONE;
      if (cnt_q == TOP_M1) up_d = 1'b0;
    end else begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) up_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt           = cnt_q;
  assign flags.at_peak = en && (cnt_q == TOP);
  assign flags.wrap    = (cnt_d == '0);
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            hi,
  output logic            lo
);
  localparam logic [DT_W-1:0] RUN_MAX = '1;

  logic            raw_q, raw_d;
  logic [DT_W-1:0] run_q, run_d;
  logic            hi_q, hi_d, lo_q, lo_d;
  logic            changed;

  // run_d counts cycles the raw level has been stable, saturating
  always_comb begin
    changed = (raw != raw_q);
    raw_d   = en ? raw : 1'b0;
    if (!en || changed)        run_d = '0;
    else if (run_q == RUN_MAX) run_d = RUN_MAX;
    else                       run_d = run_q + DT_W'(1);
    hi_d = en &&  raw && (run_d >= dt);
    lo_d = en && !raw && (run_d >= dt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      run_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      raw_q <= raw_d;
      run_q <= run_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;
endmodule

// File: rtl/pwm_irq_gen.sv
module pwm_irq_gen #(
  parameter int DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast_peak,
  input  logic slow_wrap,
  output logic irq
);
  localparam int STAGES = (DLY < 1) ? 1 : DLY;

  logic              pair_q, pair_d;
  logic              req;
  logic [STAGES-1:0] pipe_q, pipe_d;

  // pair_q marks the second peak of each pair; realigned at the slow wrap
  always_comb begin
    pair_d = pair_q;
    if (!en || slow_wrap) pair_d = 1'b0;
    else if (fast_peak)   pair_d = ~pair_q;
    req = en && fast_peak && pair_q;
    pipe_d = '0;
    if (en) begin
      pipe_d[0] = req;
      for (int k = 1; k < STAGES; k++) pipe_d[k] = pipe_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= 1'b0;
      pipe_q <= '0;
    end else begin
      pair_q <= pair_d;
      pipe_q <= pipe_d;
    end
  end

  assign irq = pipe_q[STAGES-1];
endmodule

// File: rtl/pwm_dual_timebase.sv
module pwm_dual_timebase
  import pwm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FAST_HALF = 10,
  parameter int RATIO     = 10,
  parameter int PHASES    = 3,
  parameter int DT_W      = 6,
  parameter int ISR_DLY   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [DT_W-1:0]         dead_time,
  input  logic                    pfc_cmp_wr,
  input  logic [CNT_W-1:0]        pfc_cmp_in,
  input  logic [PHASES-1:0]       inv_cmp_wr,
  input  logic [PHASES*CNT_W-1:0] inv_cmp_in,
  output logic [1:0]              pfc_pwm,
  output logic [PHASES-1:0]       inv_hi,
  output logic [PHASES-1:0]       inv_lo,
  output logic                    pfc_soc,
  output logic                    inv_soc,
  output logic                    isr_req
);
  localparam int SLOW_HALF = RATIO * FAST_HALF;
  localparam logic [CNT_W:0] FAST_TOP_X = (CNT_W+1)'(FAST_HALF);

  logic [CNT_W-1:0] fast_cnt, slow_cnt;
  tb_flags_t        fast_f, slow_f;

  // slow inverter timebase, never resynced itself
  pwm_timebase #(.CNT_W(CNT_W), .HALF(SLOW_HALF)) u_slow (
    .clk(clk), .rst_n(rst_n), .en(en), .resync(1'b0),
    .cnt(slow_cnt), .flags(slow_f)
  );

  // fast boost timebase, re-phased at every slow wrap
  pwm_timebase #(.CNT_W(CNT_W), .HALF(FAST_HALF)) u_fast (
    .clk(clk), .rst_n(rst_n), .en(en), .resync(slow_f.wrap),
    .cnt(fast_cnt), .flags(fast_f)
  );

  // ---------------- boost stage compare ----------------
  logic [CNT_W-1:0] pfc_sh_q, pfc_sh_d, pfc_act_q, pfc_act_d;
  logic             pfc_sh_ce, pfc_act_ce;
  logic [CNT_W:0]   pfc_sum;
  logic [1:0]       pfc_raw, pfc_pwm_q, pfc_pwm_d;

  always_comb begin
    pfc_sh_ce  = pfc_cmp_wr;
    pfc_act_ce = fast_f.wrap;
    pfc_sh_d   = pfc_cmp_in;
    pfc_act_d  = pfc_sh_q;
    pfc_sum    = {1'b0, fast_cnt} + {1'b0, pfc_act_q};
    pfc_raw[0] = (fast_cnt < pfc_act_q);
    pfc_raw[1] = (pfc_sum > FAST_TOP_X);
    pfc_pwm_d  = en ? pfc_raw : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfc_sh_q  <= '0;
      pfc_act_q <= '0;
      pfc_pwm_q <= 2'b00;
    end else begin
      if (pfc_sh_ce)  pfc_sh_q  <= pfc_sh_d;
      if (pfc_act_ce) pfc_act_q <= pfc_act_d;
      pfc_pwm_q <= pfc_pwm_d;
    end
  end

  assign pfc_pwm = pfc_pwm_q;

  // ---------------- inverter phases ----------------
  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    logic [CNT_W-1:0] sh_q, sh_d, act_q, act_d;
    logic             sh_ce, act_ce, raw;

    always_comb begin
      sh_ce  = inv_cmp_wr[i];
      act_ce = slow_f.wrap;
      sh_d   = inv_cmp_in[i*CNT_W +: CNT_W];
      act_d  = sh_q;
      raw    = en && (slow_cnt < act_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (sh_ce)  sh_q  <= sh_d;
        if (act_ce) act_q <= act_d;
      end
    end

    pwm_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .en(en), .raw(raw), .dt(dead_time),
      .hi(inv_hi[i]), .lo(inv_lo[i])
    );
  end

  // ---------------- triggers ----------------
  assign pfc_soc = fast_f.at_peak;
  assign inv_soc = slow_f.at_peak;

  pwm_irq_gen #(.DLY(ISR_DLY)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .fast_peak(fast_f.at_peak), .slow_wrap(slow_f.wrap),
    .irq(isr_req)
  );
endmodule

// File: rtl/pwm_dual_timebase_chk.sv
module pwm_dual_timebase_chk #(
  parameter int PHASES = 3,
  parameter int DT_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [DT_W-1:0]   dead_time,
  input logic [1:0]        pfc_pwm,
  input logic [PHASES-1:0] inv_hi,
  input logic [PHASES-1:0] inv_lo,
  input logic              pfc_soc,
  input logic              inv_soc,
  input logic              isr_req
);
  // R7: a complementary pair never conducts together
  p_no_shoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hi & inv_lo) == '0);

  // R2: outputs are quiet one edge after enable is seen low
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pfc_pwm == 2'b00 && inv_hi == '0 && inv_lo == '0 && !isr_req));

  // R10: the interrupt request lasts one cycle
  p_isr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    isr_req |=> !isr_req);

  // R3: strobes are single-cycle
  p_soc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pfc_soc |=> !pfc_soc);

  // R3: the slow peak lands on a fast valley, never on a fast peak
  p_peak_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_soc |-> !pfc_soc);

  // R6: with a dead band, a high side only rises after its low side was off
  for (genvar i = 0; i < PHASES; i++) begin : g_dt
    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dead_time != '0 && $rose(inv_hi[i])) |-> !$past(inv_lo[i]));
  end
endmodule

bind pwm_dual_timebase pwm_dual_timebase_chk #(.PHASES(PHASES), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dead_time(dead_time),
  .pfc_pwm(pfc_pwm), .inv_hi(inv_hi), .inv_lo(inv_lo),
  .pfc_soc(pfc_soc), .inv_soc(inv_soc), .isr_req(isr_req)
);

// File: tb/tb_pwm_dual_timebase.sv
module tb_pwm_dual_timebase;
  localparam int CNT_W = 16, FH = 10, RATIO = 10, PH = 3, DT_W = 6, IDLY = 3;
  localparam int SH = FH * RATIO;

  logic clk = 1'b0;
  logic rst_n, en, pfc_cmp_wr;
  logic [DT_W-1:0] dead_time;
  logic [CNT_W-1:0] pfc_cmp_in;
  logic [PH-1:0] inv_cmp_wr;
  logic [PH*CNT_W-1:0] inv_cmp_in;
  logic [1:0] pfc_pwm;
  logic [PH-1:0] inv_hi, inv_lo;
  logic pfc_soc, inv_soc, isr_req;

  int total = 0, bad = 0;
  int c_p0, c_p1, c_ps, c_is, c_irq, c_ovl;
  int c_hi[PH], c_lo[PH];

  always #5 clk = ~clk;

  pwm_dual_timebase #(.CNT_W(CNT_W), .FAST_HALF(FH), .RATIO(RATIO), .PHASES(PH),
                      .DT_W(DT_W), .ISR_DLY(IDLY)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dead_time(dead_time),
    .pfc_cmp_wr(pfc_cmp_wr), .pfc_cmp_in(pfc_cmp_in),
    .inv_cmp_wr(inv_cmp_wr), .inv_cmp_in(inv_cmp_in),
    .pfc_pwm(pfc_pwm), .inv_hi(inv_hi), .inv_lo(inv_lo),
    .pfc_soc(pfc_soc), .inv_soc(inv_soc), .isr_req(isr_req)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_pfc(input int c);
    @(negedge clk);
    pfc_cmp_in = CNT_W'(c); pfc_cmp_wr = 1'b1;
    @(negedge clk);
    pfc_cmp_wr = 1'b0;
  endtask

  task automatic set_inv(input int c0, input int c1, input int c2);
    @(negedge clk);
    inv_cmp_in = {CNT_W'(c2), CNT_W'(c1), CNT_W'(c0)}; inv_cmp_wr = '1;
    @(negedge clk);
    inv_cmp_wr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts output activity over n cycles, sampled at falling edges
  task automatic measure(input int n);
    c_p0 = 0; c_p1 = 0; c_ps = 0; c_is = 0; c_irq = 0; c_ovl = 0;
    for (int k = 0; k < PH; k++) begin c_hi[k] = 0; c_lo[k] = 0; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_p0 += int'(pfc_pwm[0]); c_p1 += int'(pfc_pwm[1]);
      c_ps += int'(pfc_soc); c_is += int'(inv_soc); c_irq += int'(isr_req);
      for (int k = 0; k < PH; k++) begin
        c_hi[k] += int'(inv_hi[k]); c_lo[k] += int'(inv_lo[k]);
        if (inv_hi[k] && inv_lo[k]) c_ovl++;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 outputs in reset",
          int'({pfc_pwm, inv_hi, inv_lo, pfc_soc, inv_soc, isr_req}), 0);
  endtask

  // first strobes after enable rises
  task automatic t_start;
    int n, f_ps, f_is, f_irq;
    f_ps = -1; f_is = -1; f_irq = -1;
    en = 1'b1;
    for (n = 1; n <= 2 * SH; n++) begin
      @(negedge clk);
      if (pfc_soc && f_ps < 0) f_ps = n;
      if (inv_soc && f_is < 0) f_is = n;
      if (isr_req && f_irq < 0) f_irq = n;
    end
    check("R2 first pfc_soc delay", f_ps, FH);
    check("R2 first inv_soc delay", f_is, SH);
    check("R10 first isr_req delay", f_irq, 3 * FH + IDLY);
  endtask

  task automatic t_rates;
    int n;
    measure(4 * SH);
    check("R3 pfc_soc per two slow periods", c_ps, 2 * RATIO);
    check("R3 inv_soc per two slow periods", c_is, 2);
    check("R10 isr_req per two slow periods", c_irq, RATIO);
    while (!inv_soc) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!pfc_soc && n < 4 * FH);
    check("R3 inv_soc to next pfc_soc gap", n, FH);
  endtask

  task automatic pfc_case(input int c, input int exp_per);
    set_pfc(c);
    idle(2 * SH + 10);
    measure(4 * SH);
    check($sformatf("R4 phase A high count c=%0d", c), c_p0, exp_per * 2 * RATIO);
    check($sformatf("R4 phase B high count c=%0d", c), c_p1, exp_per * 2 * RATIO);
  endtask

  task automatic t_pfc_duty;
    pfc_case(5, 9);
    pfc_case(0, 0);
    pfc_case(FH, 2 * FH - 1);
    pfc_case(FH + 1, 2 * FH);
  endtask

  task automatic t_phase_offset;
    set_pfc(3);
    idle(2 * SH + 10);
    while (!pfc_soc) @(negedge clk);
    check("R5 phase B high at fast peak", int'(pfc_pwm[1]), 1);
    check("R5 phase A low at fast peak", int'(pfc_pwm[0]), 0);
  endtask

  task automatic t_inv_deadtime;
    dead_time = DT_W'(3);
    set_inv(40, 0, SH);
    idle(2 * SH + 10);
    measure(4 * SH);
    check("R6 hi count c=40 dt=3", c_hi[0], 2 * 76);
    check("R6 lo count c=40 dt=3", c_lo[0], 2 * 118);
    check("R6 zero duty hi", c_hi[1], 0);
    check("R6 zero duty lo always on", c_lo[1], 4 * SH);
    check("R8 c=SH hi count", c_hi[2], 2 * (2 * SH - 1 - 3));
    check("R8 short low interval suppressed", c_lo[2], 0);
    check("R7 no overlap", c_ovl, 0);
    dead_time = '0;
    idle(2 * SH);
    measure(4 * SH);
    check("R6 hi count c=40 dt=0", c_hi[0], 2 * 79);
    check("R6 lo count c=40 dt=0", c_lo[0], 2 * 121);
    check("R7 no overlap dt=0", c_ovl, 0);
    dead_time = DT_W'(3);
  endtask

  task automatic t_shadow;
    set_inv(40, 0, SH);
    idle(2 * SH + 10);
    while (!inv_soc) @(negedge clk);
    inv_cmp_in = {CNT_W'(SH), CNT_W'(0), CNT_W'(90)}; inv_cmp_wr = '1;
    @(negedge clk);
    inv_cmp_wr = '0;
    idle(19);
    check("R9 old compare kept mid-period hi", int'(inv_hi[0]), 0);
    check("R9 old compare kept mid-period lo", int'(inv_lo[0]), 1);
    while (!inv_soc) @(negedge clk);
    idle(20);
    check("R9 new compare after wrap hi", int'(inv_hi[0]), 1);
  endtask

  task automatic t_disable;
    set_pfc(FH + 1);
    idle(2 * SH);
    @(negedge clk);
    en = 1'b0;
    idle(2);
    check("R2 outputs low while disabled",
          int'({pfc_pwm, inv_hi, inv_lo, pfc_soc, inv_soc, isr_req}), 0);
    idle(5);
    t_start();
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; dead_time = DT_W'(3);
    pfc_cmp_wr = 1'b0; pfc_cmp_in = '0; inv_cmp_wr = '0; inv_cmp_in = '0;
    idle(2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_start();
    t_rates();
    t_pfc_duty();
    t_phase_offset();
    t_inv_deadtime();
    t_shadow();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule